// File: doc/BRIEF.md
# Serial Baud Clock Generator

This block turns a fixed 2457.6 kHz reference clock into a square wave at sixteen times a chosen serial bit rate, so that a downstream UART can oversample each bit sixteen times. A three-bit rate select picks one of the standard rates. A parameter table maps each select value to an integer divisor. A down-counter then splits each divisor period into a high phase and a low phase.

A new select value is taken only at the start of a fresh output period. The period already running always finishes with its old lengths, so the output never carries a shortened pulse. The default table gives 110 baud using the nearest integer divisor for 1760 Hz. It gives 300 through 9600 baud using exact power-of-two divisors. Another table with odd divisors can be supplied through the parameter.

Top module: `baud_clk_gen`

## Requirements
- R1: While rst_n is low at a rising clock edge, the output is driven high and the divisor of the reset rate (select 6, divisor 16) is loaded, whatever rate_sel holds. The first high phase and the first low phase after reset are therefore 8 cycles each.
- R2: With the default table, the divisor for each select value is as follows. Select 0 gives 1396, the nearest integer to 2457600/1760, for 110 baud. Selects 1 to 6 give 2457600/(16*300*2^(sel-1)), that is 512, 256, 128, 64, 32 and 16, for 300 to 9600 baud. Select 7 repeats 16.
- R3: For an even divisor N, the output is high for N/2 reference cycles and then low for N/2 reference cycles.
- R4: For an odd divisor N, the output is high for (N+1)/2 cycles and then low for (N-1)/2 cycles.
- R5: A change of rate_sel takes effect only at the next rising edge of the output that ends a full period. This holds whether the change arrives during the high phase or the low phase. The period in progress keeps its old high and low lengths.
- R6: Every table entry is at least 2, so that neither phase is ever empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 2457.6 kHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_sel | input | SEL_W | Rate select, an index into the divisor table |
| baud_x16_o | output | 1 | Square wave at sixteen times the selected bit rate |

## Verification
The bench sweeps every select value. It uses the default table and also a second instance whose table holds every divisor from 2 to 9. A counter that split an odd divisor evenly, or put the extra cycle on the low side, would show a high/low count that is off by one. Changes of rate are made both in the middle of a high phase and in the middle of a low phase. A design that reloaded at once would cut the current phase short, and one that reloaded at the falling edge would give a mixed period. The bench also holds a non-default select during reset, which would expose a design that takes its first divisor from the input instead of the reset rate.

// File: rtl/baud_pkg.sv
// Shared constants for the baud clock generator.
// Assumes a 2457.6 kHz reference and eight selectable rates.
package baud_pkg;
    localparam int DEF_CNT_W     = 11;
    localparam int DEF_SEL_W     = 3;
    localparam int DEF_RESET_SEL = 6;

    // Divisor per select value, entry 0 at the right (110 baud) up to entry 7.
    localparam logic [7:0][10:0] DEFAULT_DIVS = {
        11'd16, 11'd16, 11'd32, 11'd64, 11'd128, 11'd256, 11'd512, 11'd1396
    };
endpackage

// File: rtl/baud_rate_lut.sv
// Maps a rate select to a divisor through a parameter table.
// Assumes every table entry is at least 2.
module baud_rate_lut #(
    parameter int CNT_W = baud_pkg::DEF_CNT_W,
    parameter int SEL_W = baud_pkg::DEF_SEL_W,
    parameter logic [2**SEL_W-1:0][CNT_W-1:0] TABLE = baud_pkg::DEFAULT_DIVS
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [CNT_W-1:0] div_o
);
    // Purpose: pure table lookup, no state.
    always_comb begin
        div_o = TABLE[sel_i];
    end
endmodule

// File: rtl/baud_sq_counter.sv
// Square-wave rate generator. It counts the high phase as ceil(N/2) and the
// low phase as floor(N/2) reference cycles. A new divisor is latched only
// where the low phase ends, so every period runs to completion.
// Assumes the divisor presented on next_div_i is at least 2.
module baud_sq_counter #(
    parameter int CNT_W = baud_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] next_div_i,
    input  logic [CNT_W-1:0] reset_div_i,
    output logic             sq_o
);
    logic [CNT_W-1:0] div_q;
    logic [CNT_W-1:0] cnt_q;
    logic             out_q;
    logic             phase_end;
    logic             armed_q;

    function automatic logic [CNT_W-1:0] half_up(input logic [CNT_W-1:0] n);
        return (n >> 1) + {{(CNT_W-1){1'b0}}, n[0]};
    endfunction

    function automatic logic [CNT_W-1:0] half_down(input logic [CNT_W-1:0] n);
        return n >> 1;
    endfunction

    // Purpose: flag the last cycle of the current phase.
    always_comb begin
        phase_end = (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});
    end

    // Purpose: phase counter, output level and divisor hold register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= reset_div_i;
            cnt_q <= half_up(reset_div_i);
            out_q <= 1'b1;
        end else if (phase_end) begin
            if (out_q) begin
                out_q <= 1'b0;
                cnt_q <= half_down(div_q);
            end else begin
                out_q <= 1'b1;
                div_q <= next_div_i;
                cnt_q <= half_up(next_div_i);
            end
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Purpose: mark that one non-reset cycle has passed, for $past checks.
    always_ff @(posedge clk) begin
        armed_q <= rst_n;
    end

    assign sq_o = out_q;

    // R1: reset forces the output high on the following cycle.
    p_reset_high_r1: assert property (@(posedge clk) !rst_n |=> out_q);

    // R5: the held divisor changes only where a new period starts.
    p_div_hold_r5: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        !$stable(div_q) |-> $rose(out_q));

    // R3/R4: the output moves only when the phase count was exhausted.
    p_toggle_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        (out_q != $past(out_q)) |-> ($past(cnt_q) == {{(CNT_W-1){1'b0}}, 1'b1}));

    // R4: the remaining count never exceeds the longer (high) half.
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) && (cnt_q <= half_up(div_q)));

    // R6: a divisor below 2 would empty the low phase.
    p_min_div_r6: assert property (@(posedge clk) disable iff (!rst_n)
        div_q >= 2);
endmodule

// File: rtl/baud_clk_gen.sv
// Top of the baud clock generator: table lookup feeding the square-wave
// counter. Assumes clk is the 2457.6 kHz reference and rate_sel is
// synchronous to it.
module baud_clk_gen #(
    parameter int CNT_W     = baud_pkg::DEF_CNT_W,
    parameter int SEL_W     = baud_pkg::DEF_SEL_W,
    parameter int RESET_SEL = baud_pkg::DEF_RESET_SEL,
    parameter logic [2**SEL_W-1:0][CNT_W-1:0] DIV_TABLE = baud_pkg::DEFAULT_DIVS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] rate_sel,
    output logic             baud_x16_o
);
    localparam logic [CNT_W-1:0] RESET_DIV = DIV_TABLE[RESET_SEL];

    logic [CNT_W-1:0] sel_div;

    baud_rate_lut #(
        .CNT_W (CNT_W),
        .SEL_W (SEL_W),
        .TABLE (DIV_TABLE)
    ) u_lut (
        .sel_i (rate_sel),
        .div_o (sel_div)
    );

    baud_sq_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .next_div_i  (sel_div),
        .reset_div_i (RESET_DIV),
        .sq_o        (baud_x16_o)
    );
endmodule

// File: tb/baud_clk_gen_bench.sv
module baud_clk_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sel_a = 3'd0;
    logic [2:0] sel_b = 3'd0;
    logic       out_a;
    logic       out_b;
    int         n_tests = 0;
    int         n_fail  = 0;
    int         cycles  = 0;

    always #2.5 clk = ~clk;

    baud_clk_gen u_baud_clk_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .rate_sel   (sel_a),
        .baud_x16_o (out_a)
    );

    // Second instance: divisors 2..9 cover both odd and even halves.
    baud_clk_gen #(
        .DIV_TABLE ({11'd9, 11'd8, 11'd7, 11'd6, 11'd5, 11'd4, 11'd3, 11'd2})
    ) u_baud_clk_gen_odd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rate_sel   (sel_b),
        .baud_x16_o (out_b)
    );

    function automatic int exp_div_a(input int s);
        if (s == 0) return (2457600 + 880) / 1760;
        if (s == 7) return 16;
        return 2457600 / (16 * (300 << (s - 1)));
    endfunction

    function automatic int exp_div_b(input int s);
        return s + 2;
    endfunction

    function automatic logic get_out(input bit which);
        return which ? out_b : out_a;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_rise(input bit which);
        logic prev;
        prev = get_out(which);
        @(negedge clk);
        while (!(prev == 1'b0 && get_out(which) == 1'b1)) begin
            prev = get_out(which);
            @(negedge clk);
        end
    endtask

    // Counts negedge samples at the given level; ends on the first other sample.
    task automatic run_len(input bit which, input logic lvl, output int n);
        n = 0;
        while (get_out(which) == lvl) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic set_sel(input bit which, input int s);
        if (which) sel_b = 3'(s);
        else       sel_a = 3'(s);
    endtask

    function automatic int exp_div(input bit which, input int s);
        return which ? exp_div_b(s) : exp_div_a(s);
    endfunction

    task automatic sweep(input bit which, input string req);
        int n;
        int d;
        for (int s = 0; s < 8; s++) begin
            set_sel(which, s);
            wait_rise(which);
            wait_rise(which);
            d = exp_div(which, s);
            for (int p = 0; p < 2; p++) begin
                run_len(which, 1'b1, n);
                check({req, " high"}, n, (d + 1) / 2);
                run_len(which, 1'b0, n);
                check({req, " low"}, n, d / 2);
            end
        end
    endtask

    // R5: change select in the high phase (in_low=0) or low phase (in_low=1).
    task automatic change_test(input bit which, input int a, input int b, input bit in_low);
        int n;
        int da;
        int db;
        da = exp_div(which, a);
        db = exp_div(which, b);
        set_sel(which, a);
        wait_rise(which);
        wait_rise(which);
        if (!in_low) set_sel(which, b);
        run_len(which, 1'b1, n);
        check("R5 old high kept", n, (da + 1) / 2);
        if (in_low) set_sel(which, b);
        run_len(which, 1'b0, n);
        check("R5 old low kept", n, da / 2);
        run_len(which, 1'b1, n);
        check("R5 new high", n, (db + 1) / 2);
        run_len(which, 1'b0, n);
        check("R5 new low", n, db / 2);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        sel_a = 3'd0;
        sel_b = 3'd7;
        repeat (4) @(negedge clk);
        check("R1 reset level a", int'(out_a), 1);
        check("R1 reset level b", int'(out_b), 1);
        rst_n = 1'b1;
        run_len(1'b0, 1'b1, n);
        check("R1 first high uses reset rate", n, 8);
        run_len(1'b0, 1'b0, n);
        check("R1 first low uses reset rate", n, 8);
        run_len(1'b0, 1'b1, n);
        check("R1 then select 0 applies", n, exp_div_a(0) / 2);

        sweep(1'b0, "R2 R3 default table");
        sweep(1'b1, "R3 R4 odd and even table");

        change_test(1'b0, 6, 0, 1'b0);
        change_test(1'b0, 0, 5, 1'b1);
        change_test(1'b1, 1, 7, 1'b0);
        change_test(1'b1, 7, 0, 1'b1);

        // R6: smallest divisor still yields one high and one low cycle.
        set_sel(1'b1, 0);
        wait_rise(1'b1);
        wait_rise(1'b1);
        run_len(1'b1, 1'b1, n);
        check("R6 min divisor high", n, 1);
        run_len(1'b1, 1'b0, n);
        check("R6 min divisor low", n, 1);

        // R1: reset in mid-period returns to the default rate.
        sel_a = 3'd3;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        run_len(1'b0, 1'b1, n);
        check("R1 mid-run reset high", n, 8);
        run_len(1'b0, 1'b0, n);
        check("R1 mid-run reset low", n, 8);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule